// File: doc/BRIEF.md
# Multi-Lane Marker Monitor

This block watches the alignment-marker stream of a multi-lane Ethernet PCS receiver, one tracker per lane. Each lane supplies a strobe that qualifies a received block, a flag that says the block is a marker, and a flag that says the marker word is well formed. A shared input sets the marker spacing minus one, in valid blocks. From these inputs the block derives several outputs for each lane:

- a level for a spacing fault;
- a level for a run of consecutive marker faults;
- a one-cycle pulse for a malformed marker;
- the lane's synchronization state.

It also raises a single misalignment pulse for all lanes combined. This pulse fires one metaframe after a faulty marker, but only once every lane has received a good marker at least once.

After its first good marker, a lane expects the next marker exactly gap_m1+1 valid blocks later. A marker that arrives before that slot is "early". A slot that passes with no marker is "missing". Both of these, and a malformed marker, count as marker faults. A well-formed marker that arrives in its slot is "good". It clears the lane's fault levels and resets its fault run to zero.

Top module: `lane_marker_monitor`

## Requirements
- R1: After a lane's first good marker, an early marker or a missing marker raises that lane's intv_err. intv_err is high from the cycle after the offending block and stays high until a good marker arrives in its expected slot. The slot is exactly gap_m1+1 valid blocks after the previous marker or the previous expected slot.
- R2: rpt_err of a lane rises after four consecutive marker faults on that lane, whether early, missing or malformed. It stays high until a good marker arrives. lane_sync of that lane is low while rpt_err is high.
- R3: A valid marker block with mrk_ok low produces a one-cycle mrk_bad pulse on that lane in the following cycle. This also applies before the lane's first good marker. Consecutive malformed markers give back-to-back pulses.
- R4: misalign never pulses while any lane has not yet received a good marker since reset.
- R5: Once all lanes have seen a good marker, a marker fault on any lane in a block of lane 0 causes a one-cycle misalign pulse. The pulse appears in the cycle after the (gap_m1+1)-th following lane-0 valid block, and misalign is low before that.
- R6: sync_err of a lane is high while the lane has never received a good marker or while its rpt_err is high. lane_sync is its complement.
- R7: A block with blk_vld low is ignored. It produces no mrk_bad pulse and does not advance the lane's spacing count.
- R8: In the cycle after reset, intv_err, rpt_err, mrk_bad, lane_sync and misalign are all zero and sync_err is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_vld | input | LANES | Per-lane block-valid strobe |
| mrk_det | input | LANES | Per-lane flag: this block is a marker |
| mrk_ok | input | LANES | Per-lane flag: marker word is well formed |
| gap_m1 | input | GAP_W | Marker spacing minus one, in valid blocks |
| intv_err | output | LANES | Per-lane marker spacing fault level |
| rpt_err | output | LANES | Per-lane consecutive-fault level |
| mrk_bad | output | LANES | Per-lane malformed-marker pulse |
| lane_sync | output | LANES | Per-lane synchronized state |
| sync_err | output | LANES | Per-lane sync lost or never acquired |
| misalign | output | 1 | Aggregate misalignment pulse |

## Verification
The hardest condition to reach is the misalignment pulse. It needs every lane to have acquired markers first, then a fault on one lane. The faulty lane and the others must then keep good markers in their slots while the one-metaframe delay runs. The stimulus runs this twice. In the first run one lane is kept unseen, with only a malformed marker on it, to show the pulse is suppressed. In the second run a reset is followed by markers on all lanes and a malformed marker on lane 0, and the pulse is checked in each block up to the exact block where it fires. Reaching four consecutive faults needs a mix of malformed, early and missing markers on one lane. The stimulus table walks through that mix and then confirms that one good marker clears the faults.

// File: rtl/lmm_pkg.sv
package lmm_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_GOOD  = 2'd1,
    EV_FAULT = 2'd2
  } lane_ev_t;
endpackage

// File: rtl/lmm_lane.sv
module lmm_lane #(
  parameter int GAP_W  = 14,
  parameter int REPEAT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             det,
  input  logic             ok,
  input  logic [GAP_W-1:0] gap_m1,
  output logic             intv_err,
  output logic             rpt_err,
  output logic             mrk_bad,
  output logic             lane_sync,
  output logic             sync_err,
  output logic             seen,
  output logic             fault_ev
);
  import lmm_pkg::*;
  localparam int EC_W = $clog2(REPEAT + 1);

  logic [GAP_W-1:0] cnt_q;
  logic [EC_W-1:0]  errc_q;
  logic             seen_q, intv_q, bad_q;
  logic             slot, spacing_fault;
  lane_ev_t         ev;

  assign slot = (cnt_q == '0);

  always_comb begin
    ev = EV_NONE;
    spacing_fault = 1'b0;
    if (vld && seen_q && (det || slot)) begin
      if (slot && det && ok) ev = EV_GOOD;
      else                   ev = EV_FAULT;
      spacing_fault = (det != slot);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
      errc_q <= '0;
      intv_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      bad_q <= vld && det && !ok;
      if (vld) begin
        if (!seen_q) begin
          if (det && ok) begin
            seen_q <= 1'b1;
            cnt_q  <= gap_m1;
          end
        end else begin
          if (det || slot) cnt_q <= gap_m1;
          else             cnt_q <= cnt_q - 1'b1;
          if (ev == EV_GOOD) begin
            intv_q <= 1'b0;
            errc_q <= '0;
          end else if (ev == EV_FAULT) begin
            if (spacing_fault) intv_q <= 1'b1;
            if (errc_q != EC_W'(REPEAT)) errc_q <= errc_q + 1'b1;
          end
        end
      end
    end
  end

  assign intv_err  = intv_q;
  assign rpt_err   = (errc_q == EC_W'(REPEAT));
  assign mrk_bad   = bad_q;
  assign lane_sync = seen_q && !rpt_err;
  assign sync_err  = !lane_sync;
  assign seen      = seen_q;
  assign fault_ev  = (ev == EV_FAULT);

  assert_ignore_invalid_R7: assert property (@(posedge clk) disable iff (rst)
    !vld |=> ($stable(cnt_q) && $stable(intv_q) && !mrk_bad));
  assert_intv_needs_seen_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(intv_err) |-> $past(vld && seen_q));
  assert_rpt_clear_good_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rpt_err) |-> $past(vld && det && ok));
  assert_bad_from_marker_R3: assert property (@(posedge clk) disable iff (rst)
    mrk_bad |-> $past(det));
endmodule

// File: rtl/lmm_align.sv
module lmm_align #(
  parameter int LANES = 4,
  parameter int GAP_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld0,
  input  logic [LANES-1:0] lane_seen,
  input  logic [LANES-1:0] lane_fault,
  input  logic [GAP_W-1:0] gap_m1,
  output logic             misalign
);
  logic             all_seen_q, pend_q, mis_q;
  logic [GAP_W-1:0] mcnt_q;
  logic             fire;

  assign fire = pend_q && vld0 && (mcnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      all_seen_q <= 1'b0;
      pend_q     <= 1'b0;
      mcnt_q     <= '0;
      mis_q      <= 1'b0;
    end else begin
      mis_q <= 1'b0;
      if (&lane_seen) all_seen_q <= 1'b1;
      if (fire) begin
        mis_q  <= 1'b1;
        pend_q <= 1'b0;
      end else if (pend_q && vld0) begin
        mcnt_q <= mcnt_q - 1'b1;
      end
      if (all_seen_q && vld0 && (|lane_fault) && (!pend_q || fire)) begin
        pend_q <= 1'b1;
        mcnt_q <= gap_m1;
      end
    end
  end

  assign misalign = mis_q;

  assert_misalign_armed_R4: assert property (@(posedge clk) disable iff (rst)
    misalign |-> all_seen_q);
  assert_misalign_from_pend_R5: assert property (@(posedge clk) disable iff (rst)
    misalign |-> $past(pend_q));
endmodule

// File: rtl/lane_marker_monitor.sv
module lane_marker_monitor #(
  parameter int LANES  = 4,
  parameter int GAP_W  = 14,
  parameter int REPEAT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] blk_vld,
  input  logic [LANES-1:0] mrk_det,
  input  logic [LANES-1:0] mrk_ok,
  input  logic [GAP_W-1:0] gap_m1,
  output logic [LANES-1:0] intv_err,
  output logic [LANES-1:0] rpt_err,
  output logic [LANES-1:0] mrk_bad,
  output logic [LANES-1:0] lane_sync,
  output logic [LANES-1:0] sync_err,
  output logic             misalign
);
  logic [LANES-1:0] seen, fault_ev;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lmm_lane #(.GAP_W(GAP_W), .REPEAT(REPEAT)) u_lane (
      .clk(clk), .rst(rst),
      .vld(blk_vld[g]), .det(mrk_det[g]), .ok(mrk_ok[g]), .gap_m1(gap_m1),
      .intv_err(intv_err[g]), .rpt_err(rpt_err[g]), .mrk_bad(mrk_bad[g]),
      .lane_sync(lane_sync[g]), .sync_err(sync_err[g]),
      .seen(seen[g]), .fault_ev(fault_ev[g])
    );
  end

  lmm_align #(.LANES(LANES), .GAP_W(GAP_W)) u_align (
    .clk(clk), .rst(rst), .vld0(blk_vld[0]),
    .lane_seen(seen), .lane_fault(fault_ev), .gap_m1(gap_m1),
    .misalign(misalign)
  );

  assert_sync_never_with_rpt_R6: assert property (@(posedge clk) disable iff (rst)
    |(lane_sync & rpt_err) == 1'b0);
endmodule

// File: tb/lane_marker_monitor_test.sv
module lane_marker_monitor_test;
  localparam int LANES = 4;
  localparam int GAP_W = 14;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LANES-1:0] blk_vld = '0, mrk_det = '0, mrk_ok = '0;
  logic [GAP_W-1:0] gap_m1 = GAP_W'(3);
  logic [LANES-1:0] intv_err, rpt_err, mrk_bad, lane_sync, sync_err;
  logic             misalign;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lane_marker_monitor #(.LANES(LANES), .GAP_W(GAP_W), .REPEAT(4)) uut (
    .clk(clk), .rst(rst), .blk_vld(blk_vld), .mrk_det(mrk_det), .mrk_ok(mrk_ok),
    .gap_m1(gap_m1), .intv_err(intv_err), .rpt_err(rpt_err), .mrk_bad(mrk_bad),
    .lane_sync(lane_sync), .sync_err(sync_err), .misalign(misalign)
  );

  // lane-0 script with gap_m1 = 3: {det, ok, exp intv, exp rpt, exp bad}
  localparam logic [4:0] TBL [27] = '{
    5'b11000, 5'b00000, 5'b00000, 5'b00000, 5'b11000, 5'b11100, 5'b00100,
    5'b00100, 5'b00100, 5'b11000, 5'b00000, 5'b00000, 5'b00000, 5'b10001,
    5'b10101, 5'b00100, 5'b00100, 5'b00100, 5'b00100, 5'b00100, 5'b00100,
    5'b00100, 5'b00110, 5'b00110, 5'b00110, 5'b00110, 5'b11000
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic word(input logic [3:0] v, input logic [3:0] d, input logic [3:0] o);
    blk_vld = v; mrk_det = d; mrk_ok = o;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    word(4'h0, 4'h0, 4'h0);
    word(4'h0, 4'h0, 4'h0);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R8 reset state
    check("R8 intv_err", 32'(intv_err), 0);
    check("R8 rpt_err", 32'(rpt_err), 0);
    check("R8 mrk_bad", 32'(mrk_bad), 0);
    check("R8 lane_sync", 32'(lane_sync), 0);
    check("R8 sync_err", 32'(sync_err), 32'hF);
    check("R8 misalign", 32'(misalign), 0);

    // table walk on lane 0, all lanes valid
    for (int i = 0; i < 27; i++) begin
      word(4'hF, {3'b000, TBL[i][4]}, {3'b000, TBL[i][3]});
      check($sformatf("R1 intv step %0d", i), 32'(intv_err[0]), 32'(TBL[i][2]));
      check($sformatf("R2 rpt step %0d", i), 32'(rpt_err[0]), 32'(TBL[i][1]));
      check($sformatf("R3 bad step %0d", i), 32'(mrk_bad[0]), 32'(TBL[i][0]));
      check($sformatf("R2 sync step %0d", i), 32'(lane_sync[0]), 32'(!TBL[i][1]));
    end
    check("R6 unseen lanes sync_err", 32'(sync_err[3:1]), 32'h7);
    check("R4 misalign unarmed", 32'(misalign), 0);

    // R7: invalid marker block is ignored
    word(4'h0, 4'h1, 4'h0);
    check("R7 no bad on invalid", 32'(mrk_bad[0]), 0);
    check("R7 intv unchanged", 32'(intv_err[0]), 0);
    word(4'hF, 4'h0, 4'h0);
    word(4'hF, 4'h0, 4'h0);
    word(4'hF, 4'h0, 4'h0);
    word(4'hF, 4'h1, 4'h1);
    check("R7 count frozen, slot on time", 32'(intv_err[0]), 0);

    // R4 suppression: lane 3 only malformed, never seen
    do_reset();
    word(4'hF, 4'hF, 4'h7);
    check("R3 bad before seen", 32'(mrk_bad[3]), 1);
    check("R6 lane3 still unsynced", 32'(sync_err[3]), 1);
    check("R6 lane0 synced", 32'(sync_err[0]), 0);
    for (int k = 1; k <= 12; k++) begin
      if (k == 4)                word(4'hF, 4'h7, 4'h6);
      else if (k == 8 || k == 12) word(4'hF, 4'h7, 4'h7);
      else                       word(4'hF, 4'h0, 4'h0);
      check($sformatf("R4 suppressed k=%0d", k), 32'(misalign), 0);
    end

    // R5 delayed pulse once all lanes seen
    do_reset();
    word(4'hF, 4'hF, 4'hF);
    check("R6 all synced", 32'(sync_err), 0);
    for (int k = 1; k <= 9; k++) begin
      if (k == 4)      word(4'hF, 4'hF, 4'hE);
      else if (k == 8) word(4'hF, 4'hF, 4'hF);
      else             word(4'hF, 4'h0, 4'h0);
      check($sformatf("R5 misalign k=%0d", k), 32'(misalign), (k == 8) ? 1 : 0);
    end
    check("R1 lane0 intv after malformed slot", 32'(intv_err[0]), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule